// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Edge and Centre Alignment

This block generates one pulse-width modulated waveform from a free-running channel counter. Three configuration inputs shape the waveform: a period value, a duty value and a polarity bit. An alignment bit chooses how the counter runs. In edge mode it is an up-counter that wraps. In centre mode it counts up and then back down. For the same period value, a centre-mode period is twice as long as an edge-mode period. The polarity bit sets the level the output takes at the start of each period. The output takes the opposite level once the counter is no longer below the duty value.

The block also raises a one-cycle counter-event pulse. In edge mode the pulse comes once per period. In centre mode an event-select bit chooses between a pulse at the end of the period only and a pulse at both the end and the middle of the period. A level-sensitive enable starts the channel and stops it.

Period, duty, alignment and event-select are copied into working registers while the channel is idle. While it runs, they are copied only at a period boundary, so a period never mixes two configurations. The polarity is sampled only while the channel is disabled. Changes made to it while the channel runs have no effect.

Top module: `pwm_chan`

## Requirements
- R1: In edge mode (`cfg_center`=0) with period value P ≥ 1, the counter runs 0, 1, …, P-1 and then returns to 0, so a period lasts P cycles. `wave_o` equals the polarity level while the count is below the duty value D, and the inverted level otherwise.
- R2: In centre mode (`cfg_center`=1), the counter runs 0, 1, …, P, then P-1, …, 1, and then starts the next period at 0, so a period lasts 2·P cycles. `wave_o` follows the same below-duty rule as in R1.
- R3: A period value of 0 is loaded as 1.
- R4: When D = 0, `wave_o` stays at the inverted polarity level for the whole period. When D ≥ P, it stays at the polarity level for the whole period, in both modes.
- R5: While `en`=0, `wave_o` equals the polarity most recently sampled from `cfg_pol`, which is updated at every clock edge, so a polarity change is visible after one clock edge.
- R6: While `en`=1, changes on `cfg_pol` have no effect on `wave_o`.
- R7: In edge mode, `irq_o` is high for exactly the first cycle of every period except the first period after enabling, and low otherwise.
- R8: In centre mode with `cfg_evt_mid`=0, `irq_o` behaves as in R7. With `cfg_evt_mid`=1, it is also high in the cycle that follows the cycle in which the counter held P.
- R9: Period, duty, alignment and event-select are captured at the clock edge that enables the channel, and after that only at the edge that ends a period. A change made in the middle of a period takes effect from the next period.
- R10: The first clock edge with `en`=1 starts a period at count 0. While `en`=0, the counter is held at 0, `irq_o` is low and `wave_o` follows R5. Re-enabling restarts at count 0.
- R11: After reset, `wave_o`=0 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Channel run enable |
| cfg_prd | input | WIDTH | Period value |
| cfg_dty | input | WIDTH | Duty value |
| cfg_pol | input | 1 | Start-of-period output level |
| cfg_center | input | 1 | 1 = centre (up/down) counting, 0 = edge (wrapping) counting |
| cfg_evt_mid | input | 1 | Centre mode only: also raise the event at mid-period |
| wave_o | output | 1 | PWM waveform |
| irq_o | output | 1 | One-cycle counter-event pulse |

## Verification
The assertions assume that the configuration inputs are synchronous to `clk`, and that a period value above 2^WIDTH-1 is never needed. Zero is the only period value that is treated specially. The stimulus changes every input half a cycle away from the active edge. It sweeps period values 0 through 5 and every duty value from 0 to one past the period, in all three counting variants and with both polarities. Mid-run configuration changes are also driven, so that the working-register checks see loads at real period boundaries rather than only at enable.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } cnt_dir_e;

  typedef struct packed {
    logic center;
    logic evt_mid;
  } pwm_mode_t;

endpackage

// File: rtl/pwm_chan_shadow.sv
module pwm_chan_shadow
  import pwm_chan_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] cfg_prd,
  input  logic [WIDTH-1:0] cfg_dty,
  input  pwm_mode_t        cfg_mode,
  output logic [WIDTH-1:0] prd_w,
  output logic [WIDTH-1:0] dty_w,
  output pwm_mode_t        mode_w
);

  localparam logic [WIDTH-1:0] PRD_MIN = WIDTH'(1);

  logic [WIDTH-1:0] prd_d;
  logic [WIDTH-1:0] dty_d;
  pwm_mode_t        mode_d;

  always_comb begin
    prd_d  = prd_w;
    dty_d  = dty_w;
    mode_d = mode_w;
    if (load) begin
      prd_d  = (cfg_prd == '0) ? PRD_MIN : cfg_prd;
      dty_d  = cfg_dty;
      mode_d = cfg_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_w  <= PRD_MIN;
      dty_w  <= '0;
      mode_w <= '0;
    end else begin
      prd_w  <= prd_d;
      dty_w  <= dty_d;
      mode_w <= mode_d;
    end
  end

  AST_PRD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    prd_w != '0); // R3

endmodule

// File: rtl/pwm_chan_cnt.sv
module pwm_chan_cnt
  import pwm_chan_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] prd_w,
  input  pwm_mode_t        mode_w,
  output logic [WIDTH-1:0] cnt,
  output logic             run,
  output logic             end_ev,
  output logic             mid_ev
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_d;
  cnt_dir_e         dir_q;
  cnt_dir_e         dir_d;
  logic             run_d;
  logic             going_up;

  assign going_up = (dir_q == DIR_UP);

  always_comb begin
    if (mode_w.center) begin
      mid_ev = run && going_up && (cnt == prd_w);
      end_ev = run && ((!going_up && (cnt == ONE)) ||
                       (going_up && (cnt == prd_w) && (prd_w == ONE)));
    end else begin
      mid_ev = 1'b0;
      end_ev = run && (cnt == (prd_w - ONE));
    end
  end

  always_comb begin
    cnt_d = cnt;
    dir_d = dir_q;
    run_d = run;
    if (!en) begin
      cnt_d = '0;
      dir_d = DIR_UP;
      run_d = 1'b0;
    end else if (!run) begin
      run_d = 1'b1;
    end else if (end_ev) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (mid_ev) begin
      cnt_d = cnt - ONE;
      dir_d = DIR_DN;
    end else if (going_up) begin
      cnt_d = cnt + ONE;
    end else begin
      cnt_d = cnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= DIR_UP;
      run   <= 1'b0;
    end else begin
      cnt   <= cnt_d;
      dir_q <= dir_d;
      run   <= run_d;
    end
  end

  AST_EDGE_BELOW_PRD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode_w.center) |-> (cnt < prd_w)); // R1
  AST_CTR_WITHIN_PRD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= prd_w)); // R2
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !run)); // R10

endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out
  import pwm_chan_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] prd_w,
  input  logic [WIDTH-1:0] dty_w,
  input  pwm_mode_t        mode_w,
  input  logic             end_ev,
  input  logic             mid_ev,
  input  logic             cfg_pol,
  output logic             wave_o,
  output logic             irq_o
);

  logic pol_q;
  logic pol_d;
  logic irq_d;
  logic active;

  always_comb begin
    pol_d  = en ? pol_q : cfg_pol;
    irq_d  = en && (end_ev || (mode_w.center && mode_w.evt_mid && mid_ev));
    active = (cnt < dty_w) || (dty_w >= prd_w);
    wave_o = run ? (active ? pol_q : ~pol_q) : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      pol_q <= pol_d;
      irq_o <= irq_d;
    end
  end

  AST_POL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(pol_q)); // R6
  AST_ZERO_DUTY_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && dty_w == '0 && $past(dty_w) == '0) |-> $stable(wave_o)); // R4
  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(run)); // R7

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] cfg_prd,
  input  logic [WIDTH-1:0] cfg_dty,
  input  logic             cfg_pol,
  input  logic             cfg_center,
  input  logic             cfg_evt_mid,
  output logic             wave_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] prd_w;
  logic [WIDTH-1:0] dty_w;
  pwm_mode_t        mode_w;
  pwm_mode_t        cfg_mode;
  logic [WIDTH-1:0] cnt;
  logic             run;
  logic             end_ev;
  logic             mid_ev;
  logic             load;

  assign cfg_mode = '{center: cfg_center, evt_mid: cfg_evt_mid};
  assign load     = !run || end_ev;

  pwm_chan_shadow #(.WIDTH(WIDTH)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .cfg_prd  (cfg_prd),
    .cfg_dty  (cfg_dty),
    .cfg_mode (cfg_mode),
    .prd_w    (prd_w),
    .dty_w    (dty_w),
    .mode_w   (mode_w)
  );

  pwm_chan_cnt #(.WIDTH(WIDTH)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .prd_w  (prd_w),
    .mode_w (mode_w),
    .cnt    (cnt),
    .run    (run),
    .end_ev (end_ev),
    .mid_ev (mid_ev)
  );

  pwm_chan_out #(.WIDTH(WIDTH)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .run     (run),
    .cnt     (cnt),
    .prd_w   (prd_w),
    .dty_w   (dty_w),
    .mode_w  (mode_w),
    .end_ev  (end_ev),
    .mid_ev  (mid_ev),
    .cfg_pol (cfg_pol),
    .wave_o  (wave_o),
    .irq_o   (irq_o)
  );

  AST_IRQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(mode_w.center && mode_w.evt_mid)) |-> (cnt == '0)); // R8

endmodule

// File: tb/pwm_chan_tb.sv
`timescale 1ns/1ps
module pwm_chan_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic [W-1:0] cfg_prd;
  logic [W-1:0] cfg_dty;
  logic         cfg_pol;
  logic         cfg_center;
  logic         cfg_evt_mid;
  logic         wave_o;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwm_chan #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_prd(cfg_prd), .cfg_dty(cfg_dty),
    .cfg_pol(cfg_pol), .cfg_center(cfg_center), .cfg_evt_mid(cfg_evt_mid),
    .wave_o(wave_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_p(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic exp_wave(input int t, input int p, input int d,
                                    input logic pol, input logic ctr);
    int pe = eff_p(p);
    int c;
    if (!ctr) c = t % pe;
    else begin
      int k = t % (2 * pe);
      c = (k <= pe) ? k : 2 * pe - k;
    end
    return ((c < d) || (d >= pe)) ? pol : ~pol;
  endfunction

  function automatic logic exp_irq(input int t, input int p,
                                   input logic ctr, input logic mid);
    int pe = eff_p(p);
    int per = ctr ? 2 * pe : pe;
    if (t == 0) return 1'b0;
    if (t % per == 0) return 1'b1;
    if (ctr && mid && ((t - 1) % (2 * pe)) == pe) return 1'b1;
    return 1'b0;
  endfunction

  task automatic setup(input int p, input int d, input logic pol,
                       input logic ctr, input logic mid);
    @(negedge clk);
    en = 1'b0;
    cfg_prd = W'(p); cfg_dty = W'(d); cfg_pol = pol;
    cfg_center = ctr; cfg_evt_mid = mid;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; cfg_prd = '0; cfg_dty = '0; cfg_pol = 1'b0;
    cfg_center = 1'b0; cfg_evt_mid = 1'b0;
    #1;
    chk("R11 wave", wave_o, 1'b0);
    chk("R11 irq", irq_o, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 wave after release", wave_o, 1'b0);
    chk("R11 irq after release", irq_o, 1'b0);

    // R5: polarity while idle shows after one edge
    cfg_pol = 1'b1;
    @(negedge clk);
    chk("R5 idle pol 1", wave_o, 1'b1);
    cfg_pol = 1'b0;
    @(negedge clk);
    chk("R5 idle pol 0", wave_o, 1'b0);

    // Sweep: R1 R2 R3 R4 R7 R8
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p <= 5; p++) begin
        for (int d = 0; d <= eff_p(p) + 1; d++) begin
          for (int pl = 0; pl < 2; pl++) begin
            logic ctr = (m != 0);
            logic mid = (m == 2);
            int per = ctr ? 2 * eff_p(p) : eff_p(p);
            string rw;
            string ri;
            rw = (p == 0) ? "R3" : ((d == 0 || d >= p) ? "R4" : (ctr ? "R2" : "R1"));
            ri = ctr ? "R8" : "R7";
            setup(p, d, pl[0], ctr, mid);
            for (int t = 0; t < 2 * per + 2; t++) begin
              @(negedge clk);
              chk(rw, wave_o, exp_wave(t, p, d, pl[0], ctr));
              chk(ri, irq_o, exp_irq(t, p, ctr, mid));
            end
          end
        end
      end
    end

    // R6: polarity change while running is ignored
    setup(4, 2, 1'b0, 1'b0, 1'b0);
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      chk("R6", wave_o, exp_wave(t, 4, 2, 1'b0, 1'b0));
      if (t == 2) cfg_pol = 1'b1;
    end

    // R9: mid-period change applies from next period
    setup(4, 1, 1'b0, 1'b0, 1'b0);
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      if (t < 4) begin
        chk("R9 old", wave_o, exp_wave(t, 4, 1, 1'b0, 1'b0));
        chk("R9 old irq", irq_o, exp_irq(t, 4, 1'b0, 1'b0));
      end else begin
        chk("R9 new", wave_o, exp_wave(t - 4, 6, 3, 1'b0, 1'b1));
        chk("R9 new irq", irq_o, (t == 4) ? 1'b1 : exp_irq(t - 4, 6, 1'b1, 1'b1));
      end
      if (t == 1) begin
        cfg_prd = W'(6); cfg_dty = W'(3); cfg_center = 1'b1; cfg_evt_mid = 1'b1;
      end
    end

    // R10: disable mid-period, then restart at count 0
    setup(5, 2, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R10 idle wave", wave_o, 1'b1);
    chk("R10 idle irq", irq_o, 1'b0);
    en = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      chk("R10 restart", wave_o, exp_wave(t, 5, 2, 1'b1, 1'b0));
      chk("R10 restart irq", irq_o, exp_irq(t, 5, 1'b0, 1'b0));
    end

    en = 1'b0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule